// File: doc/BRIEF.md
# HDLC Receive Frame Buffer with Block Handshake

This block sits between an HDLC receiver that has already removed flags, stuffing bits and the CRC, and a host processor. It takes received bytes one at a time, keeps them in a 64-byte store organised as two 32-byte halves, and presents them to the host in pieces. A piece is either a full block of 32 bytes, announced by a block interrupt, or the tail of a frame, announced by an end interrupt and a byte count. After each piece the host reads the bytes through a read strobe and then issues an acknowledge, which releases that piece's space for new data.

At the end of every frame the block stores one status byte carrying the CRC verdict, the abort indication and an overflow mark, so that it is the last byte the host reads. Pieces are kept in a small descriptor queue. As a result, several short frames can sit in the store and are reported one after another in arrival order, while incoming data keeps filling free space during host reads.

Top module: `hdlc_rx_pool`

## Requirements
- R1: After reset both interrupts are low and the count outputs read zero.
- R2: Every 32 stored bytes of a frame that are not its tail form a full block; when such a block is the oldest unacknowledged piece, `irq_block` is high and `host_data` shows its bytes in arrival order.
- R3: `host_ack` while a piece is pending releases that piece, and the next piece, if any, is reported in the following cycle; `host_ack` or `host_rd` with nothing pending has no effect on later data.
- R4: At frame end the remaining stored bytes plus the status byte form a tail piece of 1 to 32 bytes, reported with `irq_end`; a frame of 67 data bytes yields two full blocks and a 4-byte tail with count 68.
- R5: The status byte is stored after the last data byte of the frame, with bit 2 = CRC good, bit 1 = aborted, bit 0 = overflow, and bits 7:3 zero.
- R6: While `irq_end` is high, the 12-bit frame count (stored data bytes plus one) is split as `cnt_lo` = bits 7:0 and `cnt_hi` = bits 11:8; both read zero otherwise.
- R7: Several complete frames waiting in the store are reported one at a time, oldest first, each with its own count and acknowledged with the same `host_ack`.
- R8: A data byte is stored only when at least two bytes of the 64 are free and fewer than 7 of the 8 descriptors are in use; otherwise it is dropped and the frame's overflow bit is set. A frame that has stored nothing is dropped entirely if no byte or no descriptor is free at its end.
- R9: Incoming bytes keep being stored into free space while the host still holds an unacknowledged piece.
- R10: Each `host_rd` advances the read position by one byte within the current piece, reads past its end are ignored, and an acknowledge moves to the start of the next piece even if the current one was not fully read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One received data byte on `rx_data` this cycle |
| rx_data | input | 8 | Received data byte |
| rx_eof | input | 1 | End of the current frame (never with `rx_valid`) |
| rx_crc_ok | input | 1 | CRC verdict, valid with `rx_eof` |
| rx_abort | input | 1 | Abort indication, valid with `rx_eof` |
| host_rd | input | 1 | Host read strobe, advances the read position |
| host_ack | input | 1 | Host acknowledge of the current piece |
| host_data | output | 8 | Byte at the current read position |
| irq_block | output | 1 | Oldest piece is a full 32-byte block |
| irq_end | output | 1 | Oldest piece is a frame tail |
| cnt_lo | output | 8 | Frame count bits 7:0 |
| cnt_hi | output | 4 | Frame count bits 11:8 |

## Verification
A byte or an end marker presented before a rising edge is stored at that edge. When it completes a piece that becomes the oldest one pending, the interrupts and the count change right after that same edge. `host_data` follows the read position without a register, so it moves one edge after `host_rd`, and an acknowledge brings the next piece's flags, count and first byte one edge later. The bench drives every input at a falling edge and samples at the next falling edge. By then exactly one rising edge has passed, and it compares against a model that applies the same one-edge rule.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    parameter int unsigned BLK_BYTES = 32;
    parameter int unsigned CNT_W     = 12;
    localparam int unsigned LEN_W    = $clog2(BLK_BYTES) + 1;

    // bit positions inside the appended status byte
    localparam int unsigned ST_OVF    = 0;
    localparam int unsigned ST_ABORT  = 1;
    localparam int unsigned ST_CRC_OK = 2;

    // one piece handed to the host: a full block or a frame tail
    typedef struct packed {
        logic             is_end;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] cnt;
    } chunk_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter  int unsigned DEPTH = 64,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rxf_chunkq.sv
module rxf_chunkq
    import rxf_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  chunk_t        push_entry,
    input  logic          pop,
    output chunk_t        head,
    output logic [CW-1:0] cnt
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } cq_state_t;

    cq_state_t s_q, s_d;
    chunk_t    slot_q [DEPTH];

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = s_q.wp + AW'(1);
        if (pop)  s_d.rp = s_q.rp + AW'(1);
        s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[s_q.wp] <= push_entry;
    end

    assign head = slot_q[s_q.rp];
    assign cnt  = s_q.cnt;

    // the writer reserves room, so the queue is never pushed when full
    p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (s_q.cnt < CW'(DEPTH)));

    // pops come only from acknowledges of a pending piece
    p_no_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (s_q.cnt != '0));
endmodule

// File: rtl/rxf_wrctl.sv
module rxf_wrctl
    import rxf_pkg::*;
#(
    parameter  int unsigned DEPTH    = 64,
    parameter  int unsigned CQ_DEPTH = 8,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned FW       = AW + 1,
    localparam int unsigned QCW      = $clog2(CQ_DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_valid,
    input  logic [7:0]     rx_data,
    input  logic           rx_eof,
    input  logic           rx_crc_ok,
    input  logic           rx_abort,
    input  logic [FW-1:0]  free_bytes,
    input  logic [QCW-1:0] cq_cnt,
    output logic           we,
    output logic [AW-1:0]  waddr,
    output logic [7:0]     wdata,
    output logic           push,
    output chunk_t         push_entry
);
    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [LEN_W-1:0] fill;
        logic [CNT_W-1:0] fcnt;
        logic             ovf;
    } wr_state_t;

    wr_state_t s_q, s_d;
    logic      data_ok, stat_ok;

    always_comb begin
        s_d        = s_q;
        we         = 1'b0;
        wdata      = rx_data;
        push       = 1'b0;
        push_entry = '0;
        // one byte stays reserved for the status byte, one descriptor for the tail
        data_ok = (free_bytes > FW'(1)) && (cq_cnt < QCW'(CQ_DEPTH - 1));
        stat_ok = (free_bytes != '0) && (cq_cnt < QCW'(CQ_DEPTH));

        if (rx_valid) begin
            if (data_ok) begin
                we      = 1'b1;
                s_d.wp   = s_q.wp + AW'(1);
                s_d.fcnt = s_q.fcnt + CNT_W'(1);
                if (s_q.fill == LEN_W'(BLK_BYTES - 1)) begin
                    push              = 1'b1;
                    push_entry.is_end = 1'b0;
                    push_entry.len    = LEN_W'(BLK_BYTES);
                    push_entry.cnt    = s_q.fcnt + CNT_W'(1);
                    s_d.fill          = '0;
                end else begin
                    s_d.fill = s_q.fill + LEN_W'(1);
                end
            end else begin
                s_d.ovf = 1'b1;
            end
        end else if (rx_eof) begin
            if (stat_ok) begin
                we                = 1'b1;
                wdata             = '0;
                wdata[ST_CRC_OK]  = rx_crc_ok;
                wdata[ST_ABORT]   = rx_abort;
                wdata[ST_OVF]     = s_q.ovf;
                s_d.wp            = s_q.wp + AW'(1);
                push              = 1'b1;
                push_entry.is_end = 1'b1;
                push_entry.len    = s_q.fill + LEN_W'(1);
                push_entry.cnt    = s_q.fcnt + CNT_W'(1);
            end
            s_d.fill = '0;
            s_d.fcnt = '0;
            s_d.ovf  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign waddr = s_q.wp;

    // the receiver presents a byte and an end marker in separate cycles
    p_one_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_eof));

    // a frame that stored data always gets its status byte and tail piece
    p_status_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eof && s_q.fcnt != '0) |-> (push && push_entry.is_end && we));

    // an open block never reaches a full block without being closed
    p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fill < LEN_W'(BLK_BYTES));
endmodule

// File: rtl/hdlc_rx_pool.sv
module hdlc_rx_pool
    import rxf_pkg::*;
#(
    parameter  int unsigned N_BLKS   = 2,
    parameter  int unsigned CQ_DEPTH = 8,
    localparam int unsigned DEPTH    = BLK_BYTES * N_BLKS,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned FW       = AW + 1,
    localparam int unsigned QCW      = $clog2(CQ_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_eof,
    input  logic             rx_crc_ok,
    input  logic             rx_abort,
    input  logic             host_rd,
    input  logic             host_ack,
    output logic [7:0]       host_data,
    output logic             irq_block,
    output logic             irq_end,
    output logic [7:0]       cnt_lo,
    output logic [CNT_W-9:0] cnt_hi
);
    typedef struct packed {
        logic [FW-1:0]    free;
        logic [AW-1:0]    base;
        logic [LEN_W-1:0] roff;
    } rd_state_t;

    rd_state_t      t_q, t_d;
    logic           we, push, pending, pop;
    logic [AW-1:0]  waddr, raddr;
    logic [7:0]     wdata;
    chunk_t         push_entry, head;
    logic [QCW-1:0] cq_cnt;

    rxf_wrctl #(.DEPTH(DEPTH), .CQ_DEPTH(CQ_DEPTH)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_eof     (rx_eof),
        .rx_crc_ok  (rx_crc_ok),
        .rx_abort   (rx_abort),
        .free_bytes (t_q.free),
        .cq_cnt     (cq_cnt),
        .we         (we),
        .waddr      (waddr),
        .wdata      (wdata),
        .push       (push),
        .push_entry (push_entry)
    );

    rxf_chunkq #(.DEPTH(CQ_DEPTH)) u_cq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .cnt        (cq_cnt)
    );

    rxf_store #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (host_data)
    );

    assign pending = (cq_cnt != '0);
    assign pop     = host_ack && pending;
    assign raddr   = t_q.base + AW'(t_q.roff);

    always_comb begin
        t_d = t_q;
        if (host_rd && pending && (t_q.roff < head.len))
            t_d.roff = t_q.roff + LEN_W'(1);
        if (pop) begin
            t_d.base = t_q.base + AW'(head.len);
            t_d.roff = '0;
        end
        t_d.free = t_q.free - FW'(we) + (pop ? FW'(head.len) : FW'(0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.free <= FW'(DEPTH);
            t_q.base <= '0;
            t_q.roff <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign irq_block = pending && !head.is_end;
    assign irq_end   = pending && head.is_end;
    assign cnt_lo    = irq_end ? head.cnt[7:0] : 8'd0;
    assign cnt_hi    = irq_end ? head.cnt[CNT_W-1:8] : '0;

    // free space never exceeds the store
    p_free_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.free <= FW'(DEPTH));

    // an acknowledge with nothing pending leaves the read side untouched
    p_ack_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !pending) |=> ($stable(t_q.base) && $stable(t_q.roff)));

    // the read position stays within the current piece
    p_roff_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (t_q.roff <= head.len));
endmodule

// File: tb/tb_hdlc_rx_pool.sv
module tb_hdlc_rx_pool;
    localparam int BLK = 32;
    localparam int DEP = 64;
    localparam int CQD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0, rx_abort = 1'b0;
    logic [7:0] rx_data = '0;
    logic       host_rd = 1'b0, host_ack = 1'b0;
    logic [7:0] host_data, cnt_lo;
    logic [3:0] cnt_hi;
    logic       irq_block, irq_end;

    int n_tot = 0, n_bad = 0;
    bit finished = 0;

    // model of the store
    int m_bytes[$];
    int m_end[$], m_len[$], m_cnt[$];
    int m_free = DEP, m_fill = 0, m_fcnt = 0, m_ovf = 0;

    always #5 clk = ~clk;

    hdlc_rx_pool dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .rx_abort(rx_abort),
        .host_rd(host_rd), .host_ack(host_ack), .host_data(host_data),
        .irq_block(irq_block), .irq_end(irq_end), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tot++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int status_byte(input int crc, input int ab, input int ovf);
        return (crc << 2) | (ab << 1) | ovf;
    endfunction

    task automatic send_byte(input int b);
        rx_valid = 1'b1;
        rx_data  = b[7:0];
        @(negedge clk);
        rx_valid = 1'b0;
        if (m_free > 1 && m_len.size() < CQD - 1) begin
            m_bytes.push_back(b & 255);
            m_free--; m_fcnt++; m_fill++;
            if (m_fill == BLK) begin
                m_end.push_back(0); m_len.push_back(BLK); m_cnt.push_back(m_fcnt);
                m_fill = 0;
            end
        end else begin
            m_ovf = 1;
        end
    endtask

    task automatic end_frame(input int crc, input int ab);
        rx_eof    = 1'b1;
        rx_crc_ok = crc[0];
        rx_abort  = ab[0];
        @(negedge clk);
        rx_eof = 1'b0;
        if (m_free >= 1 && m_len.size() < CQD) begin
            m_bytes.push_back(status_byte(crc, ab, m_ovf));
            m_free--;
            m_end.push_back(1); m_len.push_back(m_fill + 1); m_cnt.push_back(m_fcnt + 1);
        end
        m_fill = 0; m_fcnt = 0; m_ovf = 0;
    endtask

    task automatic send_frame(input int n, input int seed, input int crc, input int ab);
        for (int i = 0; i < n; i++) send_byte((seed + i * 7) & 255);
        end_frame(crc, ab);
    endtask

    task automatic check_head();
        if (m_len.size() == 0) begin
            check("R3 irq_block idle", int'(irq_block), 0);
            check("R3 irq_end idle", int'(irq_end), 0);
        end else begin
            check("R2 irq_block", int'(irq_block), m_end[0] == 0 ? 1 : 0);
            check("R4 irq_end", int'(irq_end), m_end[0]);
            if (m_end[0] == 1) begin
                check("R6 cnt_lo", int'(cnt_lo), m_cnt[0] & 255);
                check("R6 cnt_hi", int'(cnt_hi), (m_cnt[0] >> 8) & 15);
            end
        end
    endtask

    // read nread bytes of the oldest piece, then acknowledge it
    task automatic drain_one(input int nread);
        int len;
        check_head();
        if (m_len.size() == 0) return;
        len = m_len[0];
        for (int k = 0; k < nread && k < len; k++) begin
            if (m_end[0] == 1 && k == len - 1)
                check("R5 status byte", int'(host_data), m_bytes[k]);
            else
                check("R2 data byte", int'(host_data), m_bytes[k]);
            host_rd = 1'b1;
            @(negedge clk);
            host_rd = 1'b0;
        end
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        for (int k = 0; k < len; k++) void'(m_bytes.pop_front());
        m_free += len;
        void'(m_end.pop_front()); void'(m_len.pop_front()); void'(m_cnt.pop_front());
    endtask

    task automatic drain_all();
        while (m_len.size() > 0) drain_one(m_len[0]);
        check_head();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tot++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 irq_block reset", int'(irq_block), 0);
        check("R1 irq_end reset", int'(irq_end), 0);
        check("R1 cnt_lo reset", int'(cnt_lo), 0);
        check("R1 cnt_hi reset", int'(cnt_hi), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: acknowledge and read with nothing pending are ignored
        host_ack = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_ack = 1'b0; host_rd = 1'b0;
        check_head();
        send_frame(4, 8'h30, 1, 0);
        check("R3 first byte after idle ack", int'(host_data), 8'h30);
        check("R6 short count", int'(cnt_lo), 5);
        drain_all();

        // R4 and R9: 67 data bytes, host frees the first block mid-frame
        for (int i = 0; i < 32; i++) send_byte(i + 1);
        check("R2 block ready", int'(irq_block), 1);
        for (int k = 0; k < 32; k++) begin
            check("R2 block byte", int'(host_data), m_bytes[k]);
            host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
        end
        for (int i = 32; i < 42; i++) send_byte(i + 1);
        check("R9 stored while block held", m_free, DEP - 42);
        host_ack = 1'b1; @(negedge clk); host_ack = 1'b0;
        for (int k = 0; k < 32; k++) void'(m_bytes.pop_front());
        m_free += 32;
        void'(m_end.pop_front()); void'(m_len.pop_front()); void'(m_cnt.pop_front());
        for (int i = 42; i < 67; i++) send_byte(i + 1);
        end_frame(1, 0);
        check("R4 second block", int'(irq_block), 1);
        drain_one(BLK);
        check("R4 tail count 68", int'(cnt_lo), 68);
        check("R4 tail length", m_len[0], 4);
        drain_all();

        // R8: overflow of a long frame without draining
        send_frame(70, 8'h55, 1, 0);
        check("R8 block after overflow", int'(irq_block), 1);
        drain_one(BLK);
        check("R8 overflow count", int'(cnt_lo), 64);
        check("R8 overflow status", m_bytes[m_len[0] - 1], 8'h05);
        drain_all();

        // R7 and R8: many short frames exhaust the descriptor queue
        for (int f = 0; f < 9; f++) send_frame(1, f * 3, f & 1, (f >> 1) & 1);
        check("R8 descriptor limit", m_len.size(), CQD);
        check("R7 first short frame", int'(cnt_lo), 2);
        drain_all();
        send_frame(5, 8'h11, 0, 1);
        send_frame(13, 8'h22, 1, 0);
        check("R7 oldest count", int'(cnt_lo), 6);
        drain_one(6);
        check("R7 next count", int'(cnt_lo), 14);
        drain_all();

        // R10: partial read, reads past the end, then acknowledge
        send_frame(40, 8'h70, 1, 1);
        drain_one(10);
        check("R10 tail after partial read", int'(host_data), m_bytes[0]);
        for (int k = 0; k < 12; k++) begin
            host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
        end
        host_ack = 1'b1; @(negedge clk); host_ack = 1'b0;
        for (int k = 0; k < m_len[0]; k++) void'(m_bytes.pop_front());
        m_free += m_len[0];
        void'(m_end.pop_front()); void'(m_len.pop_front()); void'(m_cnt.pop_front());
        send_frame(3, 8'h90, 1, 0);
        check("R10 next piece start", int'(host_data), 8'h90);
        drain_all();

        // random frames with random host service
        for (int it = 0; it < 60; it++) begin
            int n, seed, mode;
            n    = 1 + int'($urandom_range(0, 89));
            seed = int'($urandom_range(0, 255));
            send_frame(n, seed, int'($urandom_range(0, 1)), int'($urandom_range(0, 3)) == 0 ? 1 : 0);
            mode = int'($urandom_range(0, 3));
            if (mode == 0) drain_all();
            else if (mode == 1 && m_len.size() > 0) drain_one(int'($urandom_range(0, m_len[0])));
            else if (mode == 2 && m_len.size() > 0) drain_one(m_len[0]);
        end
        drain_all();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule